// File: doc/BRIEF.md
# Trusted-Module FIFO Register Front End

This block sits behind a bus slave that carries register transfers of 1 to 64 bytes at a 24-bit address. It decodes the offset of each transfer and holds the locality, status, capability and identity registers. It also tracks the command lifecycle of the trusted module. Each transfer is offered for one cycle on `req_i`, together with its direction, address, length and its first four data bytes (byte 0 in bits 7:0). Read data is returned combinationally in the same cycle, least significant byte first. Only four bytes of a read carry meaning.

The lifecycle has five states: idle, ready, receiving, executing and completing. Single-bit control writes to the status and access registers move it between them. A write of any other value is dropped. The data FIFO is a separate buffer. This block gates the buffer's write strobe by state and passes its read strobe and read data through. It mirrors the buffer's expect and data-available flags in the status word, and asks the buffer to rewind its response pointer. Toward the command processor it pulses an execute request. It waits for a response-loaded indication before entering the completing state.

Top module: `trust_fifo_regs`

## Requirements
- R1: After reset the lifecycle state is idle (`state_o` encoding: idle 0, ready 1, receiving 2, executing 3, completing 4). The access word reads 0x00000080, with bit 7 meaning register valid. The status word reads 0x04004080: family code 1 in bits 27:26, burst count 64 in bits 23:8 and status-valid bit 7.
- R2: Offset 0x014 reads 0x30000615. Offset 0xF00 reads the device ID in bits 31:16 and the vendor ID in bits 15:0. Offset 0xF04 reads the revision ID. Offsets 0x008, 0x00C, 0x010 and 0x030 read zero. Every other offset reads 0xFFFFFFFF, and writes to it are dropped.
- R3: A write to the access word (offset 0x000) uses byte 0 only. A write to the status word (offset 0x018) uses its first min(length,4) bytes. If the resulting value does not have exactly one bit set, the write changes nothing.
- R4: Writing 0x02 to the access word sets its bit 5 (locality active). Writing 0x20 clears bit 5, clears command-ready and forces idle from any state.
- R5: Writing status bit 6 (0x40) does the following. In idle it moves to ready and sets status bit 6. In ready it keeps bit 6 set. In receiving, executing or completing it moves to idle and clears bit 6.
- R6: Writing status bit 5 (0x20) in receiving while `expect_i` is low moves to executing. `exec_req_o` is then high for exactly the one cycle after the accepting edge. In any other case the write is ignored.
- R7: `resp_loaded_i` sampled high in executing moves the state to completing at that edge. In any other state it is ignored.
- R8: Writing status bit 1 (0x02) in completing pulses `rd_rewind_o` for the one cycle after the edge. In any other state it gives no pulse.
- R9: A write to offset 0x024 raises `fifo_wr_o` in the same cycle only in ready or receiving. A write in ready moves the state to receiving. A read of 0x024 raises `fifo_rd_o` and returns `fifo_rdata_i`.
- R10: Status bit 4 reflects `data_avail_i` and status bit 3 reflects `expect_i`, both combinationally.
- R11: If a control write moves the state in the same cycle that `resp_loaded_i` arrives in executing, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer strobe, one cycle per transfer |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Register offset |
| len_i | input | 7 | Transfer length in bytes (1 to 64) |
| wdata_i | input | 32 | First four write bytes, byte 0 in bits 7:0 |
| rdata_o | output | 32 | Read word, byte 0 in bits 7:0 |
| fifo_wr_o | output | 1 | Write strobe to the data buffer |
| fifo_rd_o | output | 1 | Read strobe to the data buffer |
| fifo_rdata_i | input | 32 | Read bytes from the data buffer |
| expect_i | input | 1 | Buffer needs more command bytes |
| data_avail_i | input | 1 | Buffer holds unread response bytes |
| state_o | output | 3 | Lifecycle state |
| exec_req_o | output | 1 | One-cycle execute request |
| resp_loaded_i | input | 1 | Command processor has loaded a response |
| rd_rewind_o | output | 1 | One-cycle response pointer rewind |

## Verification
Three kinds of result are due at different times. Read data and both buffer strobes are combinational, so they are due in the cycle of the request. State, locality, command-ready and the two pulses are registered once, so they are due one edge after the write or indication that causes them. The bench drives each input just after a rising edge and compares everything on the falling edge that follows. Its reference model advances on the same rising edge as the design. Directed checks on the pulses therefore sample one cycle after the request, and checks on read data sample within the request cycle.

// File: rtl/trust_fifo_pkg.sv
package trust_fifo_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int LEN_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } life_e;

  typedef enum logic [2:0] {
    RG_ACCESS, RG_STS, RG_FIFO, RG_CAP, RG_IDS, RG_REV, RG_RSVD, RG_NONE
  } reg_e;

  localparam logic [ADDR_W-1:0] OFF_ACCESS = 24'h000;
  localparam logic [ADDR_W-1:0] OFF_INT_EN = 24'h008;
  localparam logic [ADDR_W-1:0] OFF_INT_VEC = 24'h00C;
  localparam logic [ADDR_W-1:0] OFF_INT_STS = 24'h010;
  localparam logic [ADDR_W-1:0] OFF_CAP = 24'h014;
  localparam logic [ADDR_W-1:0] OFF_STS = 24'h018;
  localparam logic [ADDR_W-1:0] OFF_FIFO = 24'h024;
  localparam logic [ADDR_W-1:0] OFF_IF_ID = 24'h030;
  localparam logic [ADDR_W-1:0] OFF_IDS = 24'hF00;
  localparam logic [ADDR_W-1:0] OFF_REV = 24'hF04;

  // access word bits
  localparam int AB_VALID = 7;
  localparam int AB_ACTIVE = 5;
  localparam int AB_REQ = 1;
  // status word bits
  localparam int SB_FAM_LO = 26;
  localparam int SB_BURST_LO = 8;
  localparam int SB_VALID = 7;
  localparam int SB_CMD_RDY = 6;
  localparam int SB_GO = 5;
  localparam int SB_AVAIL = 4;
  localparam int SB_EXPECT = 3;
  localparam int SB_RETRY = 1;

  localparam logic [WORD_W-1:0] CAP_WORD = (WORD_W'(3) << 28) | (WORD_W'(3) << 9) | WORD_W'(8'h15);

  function automatic logic single_bit(input logic [WORD_W-1:0] v);
    return (v != '0) && ((v & (v - WORD_W'(1))) == '0);
  endfunction
endpackage

// File: rtl/tfr_addr_decode.sv
module tfr_addr_decode
  import trust_fifo_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_e              sel_o
);
  always_comb begin
    unique case (addr_i)
      OFF_ACCESS: sel_o = RG_ACCESS;
      OFF_STS:    sel_o = RG_STS;
      OFF_FIFO:   sel_o = RG_FIFO;
      OFF_CAP:    sel_o = RG_CAP;
      OFF_IDS:    sel_o = RG_IDS;
      OFF_REV:    sel_o = RG_REV;
      OFF_INT_EN, OFF_INT_VEC, OFF_INT_STS, OFF_IF_ID: sel_o = RG_RSVD;
      default:    sel_o = RG_NONE;
    endcase
  end
endmodule

// File: rtl/tfr_lifecycle.sv
module tfr_lifecycle
  import trust_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_we_i,
  input  logic [7:0]        acc_byte_i,
  input  logic              sts_we_i,
  input  logic [WORD_W-1:0] sts_val_i,
  input  logic              fifo_we_i,
  input  logic              expect_i,
  input  logic              resp_loaded_i,
  output life_e             state_o,
  output logic              active_o,
  output logic              cmd_ready_o,
  output logic              exec_req_o,
  output logic              rewind_o
);
  localparam logic [7:0] ACC_REQ = 8'(1) << AB_REQ;
  localparam logic [7:0] ACC_REL = 8'(1) << AB_ACTIVE;
  localparam logic [WORD_W-1:0] STS_RDY = WORD_W'(1) << SB_CMD_RDY;
  localparam logic [WORD_W-1:0] STS_GO = WORD_W'(1) << SB_GO;
  localparam logic [WORD_W-1:0] STS_RETRY = WORD_W'(1) << SB_RETRY;

  life_e state_q, state_d;
  logic  act_q, act_d, cr_q, cr_d, exec_d, rew_d, exec_q, rew_q, moved;

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    cr_d    = cr_q;
    exec_d  = 1'b0;
    rew_d   = 1'b0;
    moved   = 1'b0;
    if (acc_we_i && single_bit({{(WORD_W-8){1'b0}}, acc_byte_i})) begin
      if (acc_byte_i == ACC_REQ) begin
        act_d = 1'b1;
      end else if (acc_byte_i == ACC_REL) begin
        act_d   = 1'b0;
        cr_d    = 1'b0;
        state_d = ST_IDLE;
        moved   = 1'b1;
      end
    end
    if (sts_we_i && single_bit(sts_val_i)) begin
      if (sts_val_i == STS_RDY) begin
        moved = 1'b1;
        unique case (state_q)
          ST_IDLE:  begin state_d = ST_READY; cr_d = 1'b1; end
          ST_READY: cr_d = 1'b1;
          default:  begin state_d = ST_IDLE; cr_d = 1'b0; end
        endcase
      end else if (sts_val_i == STS_GO) begin
        if (state_q == ST_RECV && !expect_i) begin
          state_d = ST_EXEC;
          exec_d  = 1'b1;
          moved   = 1'b1;
        end
      end else if (sts_val_i == STS_RETRY) begin
        rew_d = (state_q == ST_DONE);
      end
    end
    if (fifo_we_i && state_q == ST_READY) state_d = ST_RECV;
    // a moving control write outranks the response indication
    if (!moved && state_q == ST_EXEC && resp_loaded_i) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
      cr_q    <= 1'b0;
      exec_q  <= 1'b0;
      rew_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      cr_q    <= cr_d;
      exec_q  <= exec_d;
      rew_q   <= rew_d;
    end
  end

  assign state_o     = state_q;
  assign active_o    = act_q;
  assign cmd_ready_o = cr_q;
  assign exec_req_o  = exec_q;
  assign rewind_o    = rew_q;

  // R6
  a_r6_exec_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_req_o |-> (state_o == ST_EXEC) && ($past(state_o) == ST_RECV));
  // R7
  a_r7_done_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DONE && $past(state_o) != ST_DONE) |-> ($past(state_o) == ST_EXEC) && $past(resp_loaded_i));
  // R8
  a_r8_rewind_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_o |-> $past(state_o) == ST_DONE);
  // R4
  a_r4_release_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> state_o == ST_IDLE);
  // R3
  a_r3_bad_sts_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && !single_bit(sts_val_i) && !resp_loaded_i) |=> $stable(state_o) && $stable(cmd_ready_o));
  // R5
  a_r5_ready_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_READY) |-> cmd_ready_o);
endmodule

// File: rtl/tfr_read_mux.sv
module tfr_read_mux
  import trust_fifo_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'hB7A3,
  parameter logic [15:0] VEN_ID = 16'h5E01,
  parameter logic [WORD_W-1:0] REV_ID = '0,
  parameter int unsigned FAMILY = 1,
  parameter int unsigned BURST = 64
) (
  input  reg_e              sel_i,
  input  logic              active_i,
  input  logic              cmd_ready_i,
  input  logic              expect_i,
  input  logic              data_avail_i,
  input  logic [WORD_W-1:0] fifo_rdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] sts_word, acc_word;

  always_comb begin
    sts_word = '0;
    sts_word[SB_FAM_LO +: 2] = 2'(FAMILY);
    sts_word[SB_BURST_LO +: 16] = 16'(BURST);
    sts_word[SB_VALID] = 1'b1;
    sts_word[SB_CMD_RDY] = cmd_ready_i;
    sts_word[SB_AVAIL] = data_avail_i;
    sts_word[SB_EXPECT] = expect_i;
    acc_word = '0;
    acc_word[AB_VALID] = 1'b1;
    acc_word[AB_ACTIVE] = active_i;
  end

  always_comb begin
    unique case (sel_i)
      RG_ACCESS: rdata_o = acc_word;
      RG_STS:    rdata_o = sts_word;
      RG_FIFO:   rdata_o = fifo_rdata_i;
      RG_CAP:    rdata_o = CAP_WORD;
      RG_IDS:    rdata_o = {DEV_ID, VEN_ID};
      RG_REV:    rdata_o = REV_ID;
      RG_RSVD:   rdata_o = '0;
      default:   rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/trust_fifo_regs.sv
module trust_fifo_regs
  import trust_fifo_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'hB7A3,
  parameter logic [15:0] VEN_ID = 16'h5E01,
  parameter logic [31:0] REV_ID = 32'h0,
  parameter int unsigned FAMILY = 1,
  parameter int unsigned BURST = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [23:0] addr_i,
  input  logic [6:0]  len_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        fifo_wr_o,
  output logic        fifo_rd_o,
  input  logic [31:0] fifo_rdata_i,
  input  logic        expect_i,
  input  logic        data_avail_i,
  output logic [2:0]  state_o,
  output logic        exec_req_o,
  input  logic        resp_loaded_i,
  output logic        rd_rewind_o
);
  reg_e              sel;
  life_e             state;
  logic              wr, fifo_we, active, cmd_ready;
  logic [WORD_W-1:0] byte_mask, sts_val;

  tfr_addr_decode u_decode (.addr_i(addr_i), .sel_o(sel));

  // keep only the bytes the transfer carried, at most one word
  always_comb begin
    for (int b = 0; b < WORD_BYTES; b++)
      byte_mask[8*b +: 8] = (len_i > LEN_W'(b)) ? 8'hFF : 8'h00;
  end

  assign wr      = req_i && we_i;
  assign sts_val = wdata_i & byte_mask;
  assign fifo_we = wr && (sel == RG_FIFO);

  tfr_lifecycle u_life (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_we_i     (wr && (sel == RG_ACCESS)),
    .acc_byte_i   (wdata_i[7:0]),
    .sts_we_i     (wr && (sel == RG_STS)),
    .sts_val_i    (sts_val),
    .fifo_we_i    (fifo_we),
    .expect_i     (expect_i),
    .resp_loaded_i(resp_loaded_i),
    .state_o      (state),
    .active_o     (active),
    .cmd_ready_o  (cmd_ready),
    .exec_req_o   (exec_req_o),
    .rewind_o     (rd_rewind_o)
  );

  tfr_read_mux #(
    .DEV_ID(DEV_ID), .VEN_ID(VEN_ID), .REV_ID(REV_ID), .FAMILY(FAMILY), .BURST(BURST)
  ) u_rmux (
    .sel_i       (sel),
    .active_i    (active),
    .cmd_ready_i (cmd_ready),
    .expect_i    (expect_i),
    .data_avail_i(data_avail_i),
    .fifo_rdata_i(fifo_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign fifo_wr_o = fifo_we && (state == ST_READY || state == ST_RECV);
  assign fifo_rd_o = req_i && !we_i && (sel == RG_FIFO);
  assign state_o   = state;

  // R9
  a_r9_fifo_starts_recv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && state_o == ST_READY) |=> state_o == ST_RECV);
  // R9
  a_r9_no_fifo_wr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE || state_o == ST_EXEC || state_o == ST_DONE) |-> !fifo_wr_o);
endmodule

// File: tb/trust_fifo_regs_bench.sv
module trust_fifo_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DEV = 16'h4C21;
  localparam logic [15:0] VEN = 16'h90AB;

  logic clk_i = 0, rst_ni = 0;
  logic req_i = 0, we_i = 0, expect_i = 0, data_avail_i = 0, resp_loaded_i = 0;
  logic [23:0] addr_i = 0;
  logic [6:0] len_i = 4;
  logic [31:0] wdata_i = 0, fifo_rdata_i = 32'hCAFE1234;
  logic [31:0] rdata_o;
  logic [2:0] state_o;
  logic fifo_wr_o, fifo_rd_o, exec_req_o, rd_rewind_o;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  int m_st;
  bit m_act, m_cr, m_exec, m_rew;

  trust_fifo_regs #(.DEV_ID(DEV), .VEN_ID(VEN)) u_trust_fifo_regs (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [23:0] a);
    logic [31:0] s;
    s = 32'h04004080 | (m_cr ? 32'h40 : 0) | (data_avail_i ? 32'h10 : 0) | (expect_i ? 32'h8 : 0);
    case (a)
      24'h000: return m_act ? 32'hA0 : 32'h80;
      24'h018: return s;
      24'h024: return fifo_rdata_i;
      24'h014: return 32'h30000615;
      24'hF00: return {DEV, VEN};
      24'hF04, 24'h008, 24'h00C, 24'h010, 24'h030: return 32'h0;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  // behavioural reference, advances on the same edge as the design
  always @(posedge clk_i or negedge rst_ni) begin
    int ns;
    bit moved;
    logic [31:0] v;
    if (!rst_ni) begin
      m_st = 0; m_act = 0; m_cr = 0; m_exec = 0; m_rew = 0;
    end else begin
      ns = m_st; moved = 0; m_exec = 0; m_rew = 0;
      if (req_i && we_i) begin
        if (addr_i == 24'h000) begin
          v = {24'h0, wdata_i[7:0]};
          if ($countones(v) == 1) begin
            if (v == 32'h02) m_act = 1;
            else if (v == 32'h20) begin m_act = 0; m_cr = 0; ns = 0; moved = 1; end
          end
        end else if (addr_i == 24'h018) begin
          v = wdata_i;
          if (len_i < 4) v = v & ((32'h1 << (8 * len_i)) - 1);
          if ($countones(v) == 1) begin
            if (v == 32'h40) begin
              moved = 1;
              if (m_st == 0) begin ns = 1; m_cr = 1; end
              else if (m_st == 1) m_cr = 1;
              else begin ns = 0; m_cr = 0; end
            end else if (v == 32'h20) begin
              if (m_st == 2 && !expect_i) begin ns = 3; m_exec = 1; moved = 1; end
            end else if (v == 32'h02) begin
              if (m_st == 4) m_rew = 1;
            end
          end
        end else if (addr_i == 24'h024 && m_st == 1) ns = 2;
      end
      if (!moved && m_st == 3 && resp_loaded_i) ns = 4;
      m_st = ns;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done_flag) begin
      chk({cur_req, " state"}, {29'h0, state_o}, m_st);
      chk({cur_req, " exec_req"}, {31'h0, exec_req_o}, {31'h0, m_exec});
      chk({cur_req, " rewind"}, {31'h0, rd_rewind_o}, {31'h0, m_rew});
      chk({cur_req, " fifo_wr"}, {31'h0, fifo_wr_o},
          {31'h0, req_i && we_i && addr_i == 24'h024 && (m_st == 1 || m_st == 2)});
      chk({cur_req, " fifo_rd"}, {31'h0, fifo_rd_o}, {31'h0, req_i && !we_i && addr_i == 24'h024});
      chk({cur_req, " rdata"}, rdata_o, m_read(addr_i));
    end
  end

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input logic [6:0] l = 4);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; len_i = l;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 0; addr_i = a; len_i = 4;
    #1 d = rdata_o;
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0; resp_loaded_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #(CLK_PERIOD * 3 + 2);
    rst_ni = 1;

    cur_req = "R1";
    rd(24'h000, d); chk("R1 access reset", d, 32'h80);
    rd(24'h018, d); chk("R1 sts reset", d, 32'h04004080);
    chk("R1 state reset", {29'h0, state_o}, 0);

    cur_req = "R2";
    rd(24'h014, d); chk("R2 capability", d, 32'h30000615);
    rd(24'hF00, d); chk("R2 ids", d, {DEV, VEN});
    rd(24'hF04, d); chk("R2 rev", d, 0);
    rd(24'h010, d); chk("R2 reserved", d, 0);
    rd(24'h100, d); chk("R2 unmapped", d, 32'hFFFFFFFF);
    wr(24'h01C, 32'h40); idle();
    chk("R2 unmapped write dropped", {29'h0, state_o}, 0);

    cur_req = "R3";
    wr(24'h000, 32'h22); idle();
    rd(24'h000, d); chk("R3 two-bit access dropped", d, 32'h80);
    wr(24'h018, 32'h60); idle();
    chk("R3 two-bit sts dropped", {29'h0, state_o}, 0);
    wr(24'h018, 32'h0100_0040, 1); idle();
    chk("R3 length masks upper bytes", {29'h0, state_o}, 1);
    wr(24'h018, 32'h0000_0140, 2); idle();
    chk("R3 masked two-bit kept ready", {29'h0, state_o}, 1);

    cur_req = "R5";
    wr(24'h018, 32'h40); idle();
    rd(24'h018, d); chk("R5 ready keeps cmd_ready", d, 32'h040040C0);

    cur_req = "R4";
    wr(24'h000, 32'h02); idle();
    rd(24'h000, d); chk("R4 locality active", d, 32'hA0);

    cur_req = "R9";
    fifo_rdata_i = 32'h5511AA77;
    rd(24'h024, d); chk("R9 fifo read data", d, 32'h5511AA77);
    wr(24'h024, 32'h1234); idle();
    chk("R9 fifo write enters recv", {29'h0, state_o}, 2);

    cur_req = "R10";
    expect_i = 1; data_avail_i = 1;
    rd(24'h018, d); chk("R10 flags mirrored", d, 32'h040040D8);
    data_avail_i = 0;

    cur_req = "R6";
    wr(24'h018, 32'h20); idle();
    chk("R6 go ignored with expect", {29'h0, state_o}, 2);
    expect_i = 0;
    wr(24'h018, 32'h20); idle(); #1;
    chk("R6 exec pulse", {31'h0, exec_req_o}, 1);
    chk("R6 executing", {29'h0, state_o}, 3);
    idle(); #1;
    chk("R6 pulse one cycle", {31'h0, exec_req_o}, 0);

    cur_req = "R8";
    wr(24'h018, 32'h02); idle(); #1;
    chk("R8 no rewind in exec", {31'h0, rd_rewind_o}, 0);

    cur_req = "R7";
    @(posedge clk_i); #1 resp_loaded_i = 1;
    idle();
    chk("R7 completing", {29'h0, state_o}, 4);

    cur_req = "R8";
    wr(24'h018, 32'h02); idle(); #1;
    chk("R8 rewind pulse", {31'h0, rd_rewind_o}, 1);

    cur_req = "R5";
    wr(24'h018, 32'h40); idle();
    chk("R5 cmd_ready from done to idle", {29'h0, state_o}, 0);
    wr(24'h024, 32'h99); idle();
    chk("R9 fifo write ignored in idle", {29'h0, state_o}, 0);

    cur_req = "R7";
    @(posedge clk_i); #1 resp_loaded_i = 1;
    idle();
    chk("R7 ignored in idle", {29'h0, state_o}, 0);

    cur_req = "R11";
    wr(24'h018, 32'h40); wr(24'h024, 32'h1); wr(24'h018, 32'h20); idle();
    chk("R11 in exec", {29'h0, state_o}, 3);
    wr(24'h018, 32'h40); resp_loaded_i = 1; idle();
    chk("R11 write wins", {29'h0, state_o}, 0);

    cur_req = "R4";
    wr(24'h018, 32'h40); wr(24'h024, 32'h1); idle();
    wr(24'h000, 32'h20); idle();
    chk("R4 release forces idle", {29'h0, state_o}, 0);
    rd(24'h018, d); chk("R4 release clears cmd_ready", d, 32'h04004080);
    rd(24'h000, d); chk("R4 locality cleared", d, 32'h80);
    idle(); idle();

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule